// File: doc/BRIEF.md
# Line-Locked Sine Reference PWM Generator

This block turns a digital peak-current command into a pulse-width-modulated waveform whose duty cycle traces a rectified sine that stays in step with the AC mains. A half-sine table is walked from start to end at a rate set by the measured half-cycle length. The walk restarts at every rising edge of the zero-crossing square wave. Each table value is multiplied by the peak command, and the upper bits of the product become the duty of a fixed-frequency PWM. An external low-pass filter turns this PWM into the analog current reference.

The line period is measured outside the block and arrives as a half-cycle length in clock cycles. That length is captured at each zero-crossing edge and fixes how many clocks each table entry is held. If the zero-crossing signal stops, the generator holds its output low until edges return. This keeps a stale phase from driving current into the line.

Top module: `sinref_pwm_gen`

## Requirements
- R1: While reset is high, and after reset until the first rising edge of `zc_in` is seen, `pwm_out` stays low.
- R2: The table has 256 entries of 12 bits. Entry i equals floor(4095*16*u / (5*65536 - 4*u)) with u = i*(256-i), so entry 0 is 0 and entry 128 is 4095.
- R3: On a clock where `zc_in` is high and was low at the previous clock, the table index returns to 0 and the hold counter clears. The clock after the edge uses entry 0.
- R4: At each rising edge, the hold length is captured as `half_len` shifted right by 8, with a floor of 1. Between edges, the index advances by one after each hold length of clocks and wraps from 255 to 0.
- R5: The duty value is (entry * `peak_ref`) shifted right by 18, a 6-bit number. The PWM period is 64 clocks. `pwm_out` is high while the free-running period counter is below the latched duty, so a duty of 0 gives no pulse.
- R6: The duty is latched only on the last clock of a PWM period (counter value 63). Changes to `peak_ref` or to the index in mid-period do not alter the current period.
- R7: When the number of clocks since the last rising edge reaches 4 times the `half_len` captured at that edge, the next latched duty is 0. This holds until a new rising edge arrives, after which pulses resume.
- R8: Falling edges of `zc_in` have no effect on the index, the hold counter or the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_in | input | 1 | Zero-crossing square wave; a rising edge marks a line zero crossing |
| peak_ref | input | 12 | Peak current command, unsigned |
| half_len | input | 16 | Measured half-cycle length in clocks, captured at each rising edge |
| pwm_out | output | 1 | Sinusoidally modulated PWM for external filtering |

## Verification
The hardest condition to reach from the ports is the lost-line state. Only a zero-crossing input held still for four half-cycles produces it, and only the next edge clears it. The stimulus freezes the square wave for well over the timeout, measures a full window with no pulses, then restarts the wave and checks that pulses return. Resynchronisation in mid-table is forced by restarting the square wave early, and table wrap is reached by a line period longer than the table walk. Every clock is compared against a behavioural model, which runs alongside the design through peak changes aimed at mid-period instants.

// File: rtl/sinref_pkg.sv
package sinref_pkg;

    localparam int IDX_W = 8;    // table index width (256 entries)
    localparam int AMP_W = 12;   // table amplitude width
    localparam int REF_W = 12;   // peak command width
    localparam int PWM_W = 6;    // PWM counter width (64-clock period)
    localparam int HL_W  = 16;   // half-cycle length width

    // Rational half-sine approximation: sin(pi*t) ~ 16t(1-t)/(5-4t(1-t))
    function automatic int half_sine(int i, int depth, int amax);
        longint u;
        longint den;
        u   = longint'(i) * longint'(depth - i);
        den = 5 * longint'(depth) * longint'(depth) - 4 * u;
        return int'((longint'(amax) * 16 * u) / den);
    endfunction

endpackage

// File: rtl/sinref_rom.sv
module sinref_rom #(
    parameter int IDX_W = sinref_pkg::IDX_W,
    parameter int AMP_W = sinref_pkg::AMP_W
) (
    input  logic [IDX_W-1:0] idx,
    output logic [AMP_W-1:0] amp
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int AMAX  = (1 << AMP_W) - 1;

    logic [AMP_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign rom[g] = AMP_W'(sinref_pkg::half_sine(g, DEPTH, AMAX));
    end

    assign amp = rom[idx];

endmodule

// File: rtl/sinref_phase.sv
module sinref_phase #(
    parameter int IDX_W = sinref_pkg::IDX_W,
    parameter int HL_W  = sinref_pkg::HL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc_in,
    input  logic [HL_W-1:0]  half_len,
    output logic [IDX_W-1:0] idx,
    output logic             lost
);
    localparam int SW    = HL_W - IDX_W;
    localparam int GAP_W = HL_W + 2;

    logic             zc_q;
    logic             rise;
    logic [IDX_W-1:0] idx_q;
    logic [SW-1:0]    tick_q;
    logic [SW-1:0]    step_q;
    logic [SW-1:0]    step_new;
    logic [HL_W-1:0]  exp_q;
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic             step_done;

    assign rise      = zc_in & ~zc_q;
    assign step_new  = (half_len[HL_W-1:IDX_W] == '0) ? SW'(1) : half_len[HL_W-1:IDX_W];
    assign step_done = (tick_q == step_q - SW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            zc_q   <= 1'b0;
            idx_q  <= '0;
            tick_q <= '0;
            step_q <= SW'(1);
            exp_q  <= '0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            zc_q <= zc_in;
            if (rise) begin
                idx_q  <= '0;
                tick_q <= '0;
                step_q <= step_new;
                exp_q  <= half_len;
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                if (step_done) begin
                    tick_q <= '0;
                    idx_q  <= idx_q + IDX_W'(1);
                end else begin
                    tick_q <= tick_q + SW'(1);
                end
                if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

    assign idx  = idx_q;
    assign lost = !seen_q || (gap_q >= {exp_q, 2'b00});

    p_resync_r3: assert property (@(posedge clk) disable iff (rst)
        rise |=> (idx_q == '0 && tick_q == '0));

    p_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (!rise && step_done) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!rise && !step_done) |=> $stable(idx_q));

    p_fall_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (zc_q && !zc_in) |=> (seen_q == $past(seen_q)));

endmodule

// File: rtl/sinref_pwm.sv
module sinref_pwm #(
    parameter int PWM_W = sinref_pkg::PWM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PWM_W-1:0] duty_in,
    output logic             pwm_out,
    output logic             period_end
);
    logic [PWM_W-1:0] cnt_q;
    logic [PWM_W-1:0] duty_q;

    assign period_end = &cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else begin
            cnt_q <= cnt_q + PWM_W'(1);
            if (period_end) duty_q <= duty_in;
        end
    end

    assign pwm_out = (cnt_q < duty_q);

    p_latch_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(duty_q));

    p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |-> !pwm_out);

endmodule

// File: rtl/sinref_pwm_gen.sv
module sinref_pwm_gen #(
    parameter int IDX_W = sinref_pkg::IDX_W,
    parameter int AMP_W = sinref_pkg::AMP_W,
    parameter int REF_W = sinref_pkg::REF_W,
    parameter int PWM_W = sinref_pkg::PWM_W,
    parameter int HL_W  = sinref_pkg::HL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc_in,
    input  logic [REF_W-1:0] peak_ref,
    input  logic [HL_W-1:0]  half_len,
    output logic             pwm_out
);
    localparam int PROD_W = AMP_W + REF_W;

    logic [IDX_W-1:0]  idx;
    logic              lost;
    logic [AMP_W-1:0]  amp;
    logic [PROD_W-1:0] prod;
    logic [PWM_W-1:0]  duty;
    logic              period_end;

    sinref_phase #(.IDX_W(IDX_W), .HL_W(HL_W)) u_phase (
        .clk(clk), .rst(rst), .zc_in(zc_in), .half_len(half_len),
        .idx(idx), .lost(lost)
    );

    sinref_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
        .idx(idx), .amp(amp)
    );

    always_comb begin
        prod = PROD_W'(amp) * PROD_W'(peak_ref);
        duty = lost ? '0 : prod[PROD_W-1 -: PWM_W];
    end

    sinref_pwm #(.PWM_W(PWM_W)) u_pwm (
        .clk(clk), .rst(rst), .duty_in(duty),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    p_timeout_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (lost && period_end) |=> !pwm_out);

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !pwm_out);

endmodule

// File: tb/sim_sinref_pwm_gen.sv
module sim_sinref_pwm_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        zc_in = 1'b0;
    logic [11:0] peak_ref = '0;
    logic [15:0] half_len = '0;
    logic        pwm_out;

    sinref_pwm_gen u0 (
        .clk(clk), .rst(rst), .zc_in(zc_in), .peak_ref(peak_ref),
        .half_len(half_len), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int hi_cnt = 0;
    string tag = "R1";

    // zero-crossing generator state
    bit zc_run = 0;
    int zc_per = 4096;
    int zc_hi  = 2048;
    int zc_ph  = 0;

    // behavioural reference model
    int m_zcq, m_idx, m_tick, m_step, m_exp, m_gap, m_seen, m_cnt, m_duty;
    int m_lost, m_dn;
    bit m_out = 0;

    function automatic int sine_entry(int i);
        longint u = longint'(i) * longint'(256 - i);
        return int'((64'd4095 * 16 * u) / (64'd327680 - 4 * u));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_zcq = 0; m_idx = 0; m_tick = 0; m_step = 1; m_exp = 0;
            m_gap = 0; m_seen = 0; m_cnt = 0; m_duty = 0;
        end else begin
            m_lost = (m_seen == 0 || m_gap >= 4 * m_exp) ? 1 : 0;
            m_dn   = m_lost ? 0 : ((sine_entry(m_idx) * int'(peak_ref)) >>> 18);
            if (m_cnt == 63) m_duty = m_dn;
            m_cnt = (m_cnt + 1) % 64;
            if (zc_in && m_zcq == 0) begin
                m_idx = 0; m_tick = 0; m_exp = int'(half_len);
                m_step = int'(half_len) / 256;
                if (m_step == 0) m_step = 1;
                m_gap = 0; m_seen = 1;
            end else begin
                if (m_tick == m_step - 1) begin
                    m_tick = 0;
                    m_idx = (m_idx + 1) % 256;
                end else begin
                    m_tick = m_tick + 1;
                end
                if (m_gap < 262143) m_gap = m_gap + 1;
            end
            m_zcq = zc_in ? 1 : 0;
        end
        m_out = (m_cnt < m_duty);
    end

    task automatic check(string t, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            n_chk++;
            if (pwm_out !== m_out) begin
                n_err++;
                $display("FAIL %s pwm_out actual=%0b expected=%0b t=%0t",
                         tag, pwm_out, m_out, $time);
            end
            if (pwm_out === 1'b1) hi_cnt++;
            if (zc_run) begin
                zc_in = (zc_ph < zc_hi);
                zc_ph = (zc_ph + 1) % zc_per;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_err++;
        n_chk++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset and no edge seen yet
        tag = "R1";
        cyc(4);
        check("R1 reset output", int'(pwm_out), 0);
        rst = 1'b0;
        peak_ref = 12'd4095;
        half_len = 16'd2048;
        hi_cnt = 0;
        cyc(300);
        check("R1 no pulses before first edge", hi_cnt, 0);

        // R2 / R5: full-scale tracking of the half-sine
        tag = "R2";
        zc_per = 4096; zc_hi = 2048; zc_ph = 0; zc_run = 1;
        hi_cnt = 0;
        cyc(12288);
        check("R5 pulses present at full scale", (hi_cnt > 0) ? 1 : 0, 1);

        // R6: peak changes at off-period instants
        tag = "R6";
        for (int k = 0; k < 40; k++) begin
            peak_ref = 12'((k * 997) % 4096);
            cyc(37);
        end
        peak_ref = 12'd3000;

        // R3: early zero crossing resynchronises mid-table
        tag = "R3";
        zc_run = 0; zc_in = 1'b0;
        cyc(3);
        zc_ph = 0; zc_run = 1;
        cyc(6000);

        // R4: new half-cycle length, wrap of the index, minimum hold length
        tag = "R4";
        half_len = 16'd1024; zc_per = 2048; zc_hi = 1024;
        cyc(6000);
        zc_per = 3000; zc_hi = 1500;
        cyc(6000);
        half_len = 16'd100; zc_per = 200; zc_hi = 100; zc_ph = 0;
        cyc(2000);

        // R8: short high phase, falling edge far from the half cycle
        tag = "R8";
        half_len = 16'd2048; zc_per = 4096; zc_hi = 300; zc_ph = 0;
        cyc(8192);

        // R7: lost line and recovery
        tag = "R7";
        half_len = 16'd1024; zc_per = 2048; zc_hi = 1024; zc_ph = 0;
        cyc(4096);
        zc_run = 0;
        cyc(5500);
        hi_cnt = 0;
        cyc(1000);
        check("R7 no pulses after timeout", hi_cnt, 0);
        zc_in = 1'b0; zc_ph = 0; zc_run = 1;
        hi_cnt = 0;
        cyc(3000);
        check("R7 pulses resume after edge", (hi_cnt > 0) ? 1 : 0, 1);

        // R5: zero command yields no pulse, then mid-scale
        tag = "R5";
        peak_ref = 12'd0;
        cyc(64);
        hi_cnt = 0;
        cyc(4096);
        check("R5 zero peak gives no pulse", hi_cnt, 0);
        peak_ref = 12'd2048;
        hi_cnt = 0;
        cyc(4096);
        check("R5 mid peak gives pulses", (hi_cnt > 0) ? 1 : 0, 1);

        // R1: reset in mid-run forces output low
        tag = "R1";
        rst = 1'b1;
        cyc(2);
        check("R1 reset mid-run", int'(pwm_out), 0);
        rst = 1'b0;
        cyc(200);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule